// File: doc/BRIEF.md
# Five-phase converter soft-start sequencer

This block drives the start-up of an isolated DC-DC converter that has two full bridges. It brings the converter from off to closed-loop regulation without an inrush current. It does not generate PWM or run the control loop. It produces three commands for the PWM stage: a primary-bridge duty, a secondary-bridge duty and a bridge-to-bridge phase shift. It also produces the flags that hand control to a downstream regulator.

The start-up is split into five ordered phases, P1 to P5:

- P1 ramps the primary duty with the secondary bridge off.
- P2 ramps the secondary duty to half scale.
- P3 pushes the primary duty further until a ripple detector trips.
- P4 ramps the phase shift.
- P5 snaps the primary duty to half scale and waits a bounded time.

In any phase, once either sampled output reaches its limit, the block hands over to normal mode at once. If P5 ends without that happening, the converter is stopped and a fault is raised.

All ramps advance on the ticks of a programmable divider, and each phase has its own programmable dwell limit in clock cycles. Half scale (50 %) is the value 2^(DW-1).

Top module: `softstart_seq`

## Requirements
- R1: After a synchronous active-low reset, all duty and shift outputs are 0, `phase_sel` is 0, and `handover`, `loop_en`, `sec_on` and `fault` are 0.
- R2: On the first cycle after start, the sequencer enters P1 (`phase_sel` bit 0). In P1 the primary duty starts at `v_fb[AW-1:AW-DW+1]`, capped at `pri_target`. It then rises by `pri_step` per tick, saturating at `pri_target`, while `sec_on` is 0 and the secondary duty is 0. Reaching `pri_target` on a tick moves to P2 (bit 1).
- R3: A tick occurs on the cycle when a divider, cleared on every phase change, equals `tick_div`. Ramps therefore move once per `tick_div`+1 cycles, and the first step in a phase comes `tick_div`+1 cycles after entry.
- R4: In P2 the primary duty is frozen and the secondary duty rises by `sec_step` per tick toward half scale. On reaching it, or on leaving P2 by the dwell limit, the sequencer enters P3 (bit 2) with the secondary duty at half scale.
- R5: In P3 the primary duty rises by `pri_step` per tick, capped at half scale. When `ripple_det` is high, the duty is held unchanged and P4 (bit 3) is entered on the next cycle. Reaching half scale also moves to P4.
- R6: In P4 both duties hold and `loop_en` is 0. The shift rises by `shift_step` per tick, saturating at `shift_ceiling`. Reaching the ceiling moves to P5 (bit 4), and the primary duty becomes half scale on that same edge.
- R7: If P5 reaches its dwell limit, the next state is stopped. In it, all duties and the shift are 0, `fault` is 1 and no phase bit is set.
- R8: While in P1..P5 with `enable` high, `v_fb >= v_lim` or `i_fb >= i_lim` makes the next cycle show normal mode. Normal mode is: `handover`=1, `loop_en`=1, `sec_on`=1, both duties at half scale, shift held and `phase_sel`=0.
- R9: A phase whose ramp has not finished is left after exactly its dwell limit of cycles (`lim_p1`..`lim_p5`), counted from the entry cycle.
- R10: `phase_sel` is one-hot while soft-starting and zero otherwise, and `ramp_active` is high exactly when a phase bit is set.
- R11: With `enable` low, the next cycle shows all duties and the shift at 0 and no phase active. `fault` keeps its value while disabled and clears on the cycle a new start enters P1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Start request; low forces off |
| v_fb | input | AW | Sampled output voltage |
| i_fb | input | AW | Sampled output current |
| v_lim | input | AW | Voltage handover limit |
| i_lim | input | AW | Current handover limit |
| ripple_det | input | 1 | Output fluctuation detected |
| pri_target | input | DW | Primary duty end value for P1 |
| shift_ceiling | input | PW | Upper bound of the P4 shift ramp |
| pri_step | input | DW | Primary ramp increment per tick |
| sec_step | input | DW | Secondary ramp increment per tick |
| shift_step | input | PW | Shift ramp increment per tick |
| tick_div | input | PSW | Ramp divider; ticks every tick_div+1 cycles |
| lim_p1 | input | TW | Dwell limit of P1 in cycles |
| lim_p2 | input | TW | Dwell limit of P2 in cycles |
| lim_p3 | input | TW | Dwell limit of P3 in cycles |
| lim_p4 | input | TW | Dwell limit of P4 in cycles |
| lim_p5 | input | TW | Dwell limit of P5 in cycles |
| pri_duty | output | DW | Primary bridge duty command |
| sec_duty | output | DW | Secondary bridge duty command |
| shift_cmd | output | PW | Bridge phase-shift command |
| sec_on | output | 1 | Secondary bridge switching enabled |
| phase_sel | output | 5 | One-hot active phase, bit 0 = P1 |
| ramp_active | output | 1 | Soft-start in progress |
| handover | output | 1 | Normal mode reached |
| loop_en | output | 1 | Enable for the downstream regulator |
| fault | output | 1 | Start-up failed |

## Verification
The bench builds the block with its default parameters: 10-bit duties and shift, 12-bit samples, 16-bit dwell counters and an 8-bit divider. Half scale is then 512, and the initial duty is the top nine sample bits. A sample of 4000 therefore exceeds a 200 target and exercises the cap.

With a divider of 2, the ramp timing can be seen cycle by cycle. A divider of 0 together with a zero primary step forces a dwell-limit exit after fifteen cycles. Short P5 limits make the fault path reachable within a few hundred cycles.

// File: rtl/softstart_pkg.sv
// Shared types for the soft-start sequencer.
// Assumes: the state encoding places P1..P5 at values 1..5, and the
// phase-select decode relies on that order.
package softstart_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_P1    = 3'd1,
        ST_P2    = 3'd2,
        ST_P3    = 3'd3,
        ST_P4    = 3'd4,
        ST_P5    = 3'd5,
        ST_RUN   = 3'd6,
        ST_STOP  = 3'd7
    } ss_state_e;

    localparam int NUM_PHASES = 5;

endpackage

// File: rtl/ss_tick_div.sv
// Ramp tick divider.
// Emits one tick every div+1 cycles. A clear restarts the count so the
// first tick after a clear comes div+1 cycles later.
// Assumes: clr is high on the edge where the consumer changes phase.
module ss_tick_div #(
    parameter int PSW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic [PSW-1:0] div,
    output logic           tick
);

    logic [PSW-1:0] cnt_q;

    // tick fires when the count equals the programmed divider
    assign tick = (cnt_q == div);

    // count register: restart on clear or after a tick
    always_ff @(posedge clk) begin
        if (!rst_n || clr || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PSW'(1);
        end
    end

endmodule

// File: rtl/ss_dwell_timer.sv
// Phase dwell timer.
// Counts cycles spent in the current phase and flags the cycle on which the
// count reaches limit-1, i.e. the last allowed cycle of the phase.
// Assumes: clr is high on the edge that changes phase; the count saturates.
module ss_dwell_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [TW-1:0] limit,
    output logic          expired
);

    localparam logic [TW-1:0] CNT_MAX = '1;

    logic [TW-1:0] cnt_q;
    logic [TW:0]   cnt_next_w;

    // compare in one extra bit so a full count cannot wrap
    assign cnt_next_w = {1'b0, cnt_q} + (TW+1)'(1);
    assign expired    = (cnt_next_w >= {1'b0, limit});

    // dwell count register with saturation
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + TW'(1);
        end
    end

endmodule

// File: rtl/ss_sat_ramp.sv
// Saturating ramp step.
// Combinational: proposes cur+step clipped to lim, and reports whether the
// proposed value equals the limit.
// Assumes: cur <= lim in normal use; a larger cur is pulled down to lim.
module ss_sat_ramp #(
    parameter int W = 10
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] step,
    input  logic [W-1:0] lim,
    output logic [W-1:0] nxt,
    output logic         at_lim
);

    logic [W:0] sum_w;

    // widened sum, clipped at the limit
    always_comb begin
        sum_w  = {1'b0, cur} + {1'b0, step};
        at_lim = (sum_w >= {1'b0, lim});
        nxt    = at_lim ? lim : sum_w[W-1:0];
    end

endmodule

// File: rtl/softstart_seq.sv
// Five-phase soft-start sequencer for a two-bridge isolated converter.
// Steps primary duty, secondary duty, more primary duty, phase shift and a
// final primary jump, leaving for normal mode as soon as either output sample
// reaches its limit. A phase that runs out of dwell time moves on; running
// out in the last phase stops the converter with a fault.
// Assumes: pri_target <= half scale; inputs are synchronous to clk.
module softstart_seq #(
    parameter int DW  = 10,
    parameter int AW  = 12,
    parameter int PW  = 10,
    parameter int TW  = 16,
    parameter int PSW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable,
    input  logic [AW-1:0]  v_fb,
    input  logic [AW-1:0]  i_fb,
    input  logic [AW-1:0]  v_lim,
    input  logic [AW-1:0]  i_lim,
    input  logic           ripple_det,
    input  logic [DW-1:0]  pri_target,
    input  logic [PW-1:0]  shift_ceiling,
    input  logic [DW-1:0]  pri_step,
    input  logic [DW-1:0]  sec_step,
    input  logic [PW-1:0]  shift_step,
    input  logic [PSW-1:0] tick_div,
    input  logic [TW-1:0]  lim_p1,
    input  logic [TW-1:0]  lim_p2,
    input  logic [TW-1:0]  lim_p3,
    input  logic [TW-1:0]  lim_p4,
    input  logic [TW-1:0]  lim_p5,
    output logic [DW-1:0]  pri_duty,
    output logic [DW-1:0]  sec_duty,
    output logic [PW-1:0]  shift_cmd,
    output logic           sec_on,
    output logic [4:0]     phase_sel,
    output logic           ramp_active,
    output logic           handover,
    output logic           loop_en,
    output logic           fault
);

    import softstart_pkg::*;

    localparam logic [DW-1:0] HALF_DUTY = {1'b1, {(DW-1){1'b0}}};
    localparam int            INIT_W    = DW - 1;

    ss_state_e     state_q, state_d;
    logic [DW-1:0] pri_q, pri_d;
    logic [DW-1:0] sec_q, sec_d;
    logic [PW-1:0] sh_q, sh_d;
    logic          fault_q, fault_d;

    logic          tick;
    logic          dwell_out;
    logic          phase_chg;
    logic [TW-1:0] dwell_lim;
    logic          limit_hit;
    logic          in_phase;
    logic [DW-1:0] init_raw;
    logic [DW-1:0] init_duty;
    logic [DW-1:0] pri_cap;
    logic [DW-1:0] pri_nxt, sec_nxt;
    logic [PW-1:0] sh_nxt;
    logic          pri_full, sec_full, sh_full;

    // starting primary duty from the top sample bits, capped at the target
    always_comb begin
        init_raw  = {1'b0, v_fb[AW-1 -: INIT_W]};
        init_duty = (init_raw > pri_target) ? pri_target : init_raw;
    end

    // handover condition on either sampled output
    assign limit_hit = (v_fb >= v_lim) || (i_fb >= i_lim);
    assign in_phase  = (state_q == ST_P1) || (state_q == ST_P2) ||
                       (state_q == ST_P3) || (state_q == ST_P4) ||
                       (state_q == ST_P5);

    // primary ramp ceiling: target in P1, half scale afterwards
    assign pri_cap = (state_q == ST_P1) ? pri_target : HALF_DUTY;

    // dwell limit of the phase currently active
    always_comb begin
        case (state_q)
            ST_P1:   dwell_lim = lim_p1;
            ST_P2:   dwell_lim = lim_p2;
            ST_P3:   dwell_lim = lim_p3;
            ST_P4:   dwell_lim = lim_p4;
            ST_P5:   dwell_lim = lim_p5;
            default: dwell_lim = '1;
        endcase
    end

    ss_sat_ramp #(.W(DW)) u_pri_ramp (
        .cur(pri_q), .step(pri_step), .lim(pri_cap),
        .nxt(pri_nxt), .at_lim(pri_full)
    );

    ss_sat_ramp #(.W(DW)) u_sec_ramp (
        .cur(sec_q), .step(sec_step), .lim(HALF_DUTY),
        .nxt(sec_nxt), .at_lim(sec_full)
    );

    ss_sat_ramp #(.W(PW)) u_sh_ramp (
        .cur(sh_q), .step(shift_step), .lim(shift_ceiling),
        .nxt(sh_nxt), .at_lim(sh_full)
    );

    assign phase_chg = (state_d != state_q);

    ss_tick_div #(.PSW(PSW)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(phase_chg),
        .div(tick_div), .tick(tick)
    );

    ss_dwell_timer #(.TW(TW)) u_dwell (
        .clk(clk), .rst_n(rst_n), .clr(phase_chg),
        .limit(dwell_lim), .expired(dwell_out)
    );

    // next-state and next-command selection
    always_comb begin
        state_d = state_q;
        pri_d   = pri_q;
        sec_d   = sec_q;
        sh_d    = sh_q;
        fault_d = fault_q;
        if (!enable) begin
            state_d = ST_OFF;
            pri_d   = '0;
            sec_d   = '0;
            sh_d    = '0;
        end else if (in_phase && limit_hit) begin
            state_d = ST_RUN;
            pri_d   = HALF_DUTY;
            sec_d   = HALF_DUTY;
        end else begin
            case (state_q)
                ST_OFF: begin
                    state_d = ST_P1;
                    pri_d   = init_duty;
                    sec_d   = '0;
                    sh_d    = '0;
                    fault_d = 1'b0;
                end
                ST_P1: begin
                    if (tick) pri_d = pri_nxt;
                    if ((tick && pri_full) || dwell_out) state_d = ST_P2;
                end
                ST_P2: begin
                    if (tick) sec_d = sec_nxt;
                    if ((tick && sec_full) || dwell_out) begin
                        state_d = ST_P3;
                        sec_d   = HALF_DUTY;
                    end
                end
                ST_P3: begin
                    if (ripple_det) begin
                        state_d = ST_P4;
                    end else begin
                        if (tick) pri_d = pri_nxt;
                        if ((tick && pri_full) || dwell_out) state_d = ST_P4;
                    end
                end
                ST_P4: begin
                    if (tick) sh_d = sh_nxt;
                    if ((tick && sh_full) || dwell_out) begin
                        state_d = ST_P5;
                        pri_d   = HALF_DUTY;
                    end
                end
                ST_P5: begin
                    if (dwell_out) begin
                        state_d = ST_STOP;
                        pri_d   = '0;
                        sec_d   = '0;
                        sh_d    = '0;
                        fault_d = 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // state and command registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            pri_q   <= '0;
            sec_q   <= '0;
            sh_q    <= '0;
            fault_q <= 1'b0;
        end else begin
            state_q <= state_d;
            pri_q   <= pri_d;
            sec_q   <= sec_d;
            sh_q    <= sh_d;
            fault_q <= fault_d;
        end
    end

    // one-hot phase decode, bit g for phase g+1
    for (genvar g = 0; g < NUM_PHASES; g++) begin : g_phase
        assign phase_sel[g] = (state_q == ss_state_e'(3'(g + 1)));
    end

    assign pri_duty    = pri_q;
    assign sec_duty    = sec_q;
    assign shift_cmd   = sh_q;
    assign fault       = fault_q;
    assign ramp_active = in_phase;
    assign handover    = (state_q == ST_RUN);
    assign loop_en     = (state_q == ST_RUN);
    assign sec_on      = (state_q == ST_P2) || (state_q == ST_P3) ||
                         (state_q == ST_P4) || (state_q == ST_P5) ||
                         (state_q == ST_RUN);

endmodule

// File: rtl/softstart_seq_chk.sv
// Property checker for the soft-start sequencer, attached by bind.
// Observes ports only; assumes the sequencer's synchronous active-low reset.
module softstart_seq_chk #(
    parameter int DW  = 10,
    parameter int AW  = 12,
    parameter int PW  = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic [AW-1:0] v_fb,
    input logic [AW-1:0] i_fb,
    input logic [AW-1:0] v_lim,
    input logic [AW-1:0] i_lim,
    input logic [PW-1:0] shift_ceiling,
    input logic [DW-1:0] pri_duty,
    input logic [DW-1:0] sec_duty,
    input logic [PW-1:0] shift_cmd,
    input logic          sec_on,
    input logic [4:0]    phase_sel,
    input logic          ramp_active,
    input logic          handover,
    input logic          loop_en,
    input logic          fault
);

    AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phase_sel) && (ramp_active == (phase_sel != 5'd0))); // R10

    AST_P1_SEC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        phase_sel[0] |-> (!sec_on && sec_duty == '0)); // R2

    AST_P2_PRI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        phase_sel[1] |=> (!phase_sel[1] || $stable(pri_duty))); // R4

    AST_P4_LOOP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        phase_sel[3] |-> (!loop_en && shift_cmd <= shift_ceiling)); // R6

    AST_STOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (pri_duty == '0 && sec_duty == '0 && shift_cmd == '0 && !ramp_active)); // R7

    AST_LIMIT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && ramp_active && ((v_fb >= v_lim) || (i_fb >= i_lim)))
        |=> (handover && loop_en)); // R8

    AST_HANDOVER_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        handover |-> (loop_en && sec_on && phase_sel == 5'd0)); // R8

    AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (pri_duty == '0 && sec_duty == '0 && shift_cmd == '0 && !handover)); // R11

endmodule

bind softstart_seq softstart_seq_chk #(.DW(DW), .AW(AW), .PW(PW)) u_chk (.*);

// File: tb/sim_softstart_seq.sv
`timescale 1ns/1ps
// Bench for the soft-start sequencer: behavioural reference model stepped
// on every clock and compared against all outputs, plus directed checks.
module sim_softstart_seq;

    localparam int DW = 10, AW = 12, PW = 10, TW = 16, PSW = 8;
    localparam int HALF = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic [AW-1:0] v_fb = '0, i_fb = '0, v_lim = '1, i_lim = '1;
    logic ripple_det = 1'b0;
    logic [DW-1:0] pri_target = 10'd200;
    logic [PW-1:0] shift_ceiling = 10'd100;
    logic [DW-1:0] pri_step = 10'd20, sec_step = 10'd64;
    logic [PW-1:0] shift_step = 10'd5;
    logic [PSW-1:0] tick_div = 8'd2;
    logic [TW-1:0] lim_p1 = 16'd200, lim_p2 = 16'd100, lim_p3 = 16'd100;
    logic [TW-1:0] lim_p4 = 16'd200, lim_p5 = 16'd20;
    logic [DW-1:0] pri_duty, sec_duty;
    logic [PW-1:0] shift_cmd;
    logic sec_on, ramp_active, handover, loop_en, fault;
    logic [4:0] phase_sel;

    softstart_seq #(.DW(DW), .AW(AW), .PW(PW), .TW(TW), .PSW(PSW)) u0 (.*);

    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    // reference model state: 0 off, 1..5 phases, 6 normal, 7 stopped
    int m_st = 0, m_pri = 0, m_sec = 0, m_sh = 0, m_fault = 0, m_pc = 0, m_tc = 0;
    string tagv[8] = '{"R11", "R2", "R4", "R5", "R6", "R7", "R8", "R7"};

    function automatic int clip(int c, int s, int l);
        return (c + s >= l) ? l : c + s;
    endfunction

    function automatic int dwell(int st);
        case (st)
            1: return int'(lim_p1);
            2: return int'(lim_p2);
            3: return int'(lim_p3);
            4: return int'(lim_p4);
            5: return int'(lim_p5);
            default: return 65535;
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // reference model step at each edge, then full output comparison
    always @(posedge clk) begin
        int ns, init, tk, hit, thr;
        if (!rst_n) begin
            m_st = 0; m_pri = 0; m_sec = 0; m_sh = 0; m_fault = 0; m_pc = 0; m_tc = 0;
        end else begin
            tk  = (m_pc == int'(tick_div));
            hit = (m_tc + 1 >= dwell(m_st));
            thr = (v_fb >= v_lim) || (i_fb >= i_lim);
            init = int'(v_fb) / 8;
            if (init > int'(pri_target)) init = int'(pri_target);
            ns = m_st;
            if (!enable) begin
                ns = 0; m_pri = 0; m_sec = 0; m_sh = 0;
            end else if (m_st >= 1 && m_st <= 5 && thr) begin
                ns = 6; m_pri = HALF; m_sec = HALF;
            end else if (m_st == 0) begin
                ns = 1; m_pri = init; m_sec = 0; m_sh = 0; m_fault = 0;
            end else if (m_st == 1) begin
                if (tk) m_pri = clip(m_pri, int'(pri_step), int'(pri_target));
                if ((tk && m_pri == int'(pri_target)) || hit) ns = 2;
            end else if (m_st == 2) begin
                if (tk) m_sec = clip(m_sec, int'(sec_step), HALF);
                if ((tk && m_sec == HALF) || hit) begin ns = 3; m_sec = HALF; end
            end else if (m_st == 3) begin
                if (ripple_det) ns = 4;
                else begin
                    if (tk) m_pri = clip(m_pri, int'(pri_step), HALF);
                    if ((tk && m_pri == HALF) || hit) ns = 4;
                end
            end else if (m_st == 4) begin
                if (tk) m_sh = clip(m_sh, int'(shift_step), int'(shift_ceiling));
                if ((tk && m_sh == int'(shift_ceiling)) || hit) begin ns = 5; m_pri = HALF; end
            end else if (m_st == 5) begin
                if (hit) begin ns = 7; m_pri = 0; m_sec = 0; m_sh = 0; m_fault = 1; end
            end
            if (ns != m_st) begin m_pc = 0; m_tc = 0; end
            else begin m_pc = tk ? 0 : m_pc + 1; if (m_tc < 65535) m_tc++; end
            m_st = ns;
        end
        #1;
        check({tagv[m_st], " pri_duty"}, int'(pri_duty), m_pri);
        check({tagv[m_st], " sec_duty"}, int'(sec_duty), m_sec);
        check({tagv[m_st], " shift_cmd"}, int'(shift_cmd), m_sh);
        check("R10 phase_sel", int'(phase_sel), (m_st >= 1 && m_st <= 5) ? (1 << (m_st - 1)) : 0);
        check("R10 ramp_active", int'(ramp_active), int'(m_st >= 1 && m_st <= 5));
        check("R8 handover", int'(handover), int'(m_st == 6));
        check("R8 loop_en", int'(loop_en), int'(m_st == 6));
        check({tagv[m_st], " sec_on"}, int'(sec_on), int'(m_st >= 2 && m_st <= 6));
        check("R11 fault", int'(fault), m_fault);
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<=100000", cyc);
            finish_run();
        end
    end

    task automatic wait_state(int st);
        for (int k = 0; k < 5000 && m_st != st; k++) @(negedge clk);
    endtask

    initial begin
        int held, cnt;
        repeat (3) @(negedge clk);
        check("R1 pri_duty", int'(pri_duty), 0);
        check("R1 phase_sel", int'(phase_sel), 0);
        check("R1 fault", int'(fault), 0);
        check("R1 handover", int'(handover), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // run to fault: initial duty 80/8 = 10, divider 2
        v_fb = 12'd80;
        enable = 1'b1;
        @(negedge clk);
        check("R2 initial duty", int'(pri_duty), 10);
        check("R2 phase P1", int'(phase_sel), 1);
        repeat (2) @(negedge clk);
        check("R3 no step before tick", int'(pri_duty), 10);
        @(negedge clk);
        check("R3 first step", int'(pri_duty), 30);
        wait_state(3);
        check("R4 secondary at half", int'(sec_duty), HALF);
        check("R4 primary held", int'(pri_duty), 200);
        wait_state(5);
        check("R6 shift at ceiling", int'(shift_cmd), 100);
        check("R7 primary half in P5", int'(pri_duty), HALF);
        check("R10 P5 bit", int'(phase_sel), 16);
        wait_state(7);
        check("R7 fault raised", int'(fault), 1);
        check("R7 duty zero", int'(pri_duty), 0);

        // disable keeps fault, restart clears it
        enable = 1'b0;
        @(negedge clk);
        check("R11 fault kept", int'(fault), 1);
        check("R11 duty zero", int'(sec_duty), 0);
        enable = 1'b1;
        @(negedge clk);
        check("R11 fault cleared", int'(fault), 0);

        // ripple latch in P3, then current limit exit in P4
        wait_state(3);
        repeat (4) @(negedge clk);
        held = int'(pri_duty);
        ripple_det = 1'b1;
        @(negedge clk);
        ripple_det = 1'b0;
        check("R5 P4 entered", int'(phase_sel), 8);
        check("R5 duty latched", int'(pri_duty), held);
        repeat (7) @(negedge clk);
        held = int'(shift_cmd);
        i_fb = 12'd900; i_lim = 12'd900;
        @(negedge clk);
        check("R8 handover", int'(handover), 1);
        check("R8 shift held", int'(shift_cmd), held);
        check("R8 primary half", int'(pri_duty), HALF);
        enable = 1'b0; i_fb = '0; i_lim = '1;
        @(negedge clk);

        // dwell exit of P1 with zero step, divider 0
        pri_step = '0; tick_div = '0; lim_p1 = 16'd15;
        enable = 1'b1;
        @(negedge clk);
        cnt = 0;
        while (phase_sel == 5'd1 && cnt < 100) begin cnt++; @(negedge clk); end
        check("R9 P1 dwell cycles", cnt, 15);
        check("R4 secondary starts at 0", int'(sec_duty), 0);
        @(negedge clk);
        check("R3 tick every cycle", int'(sec_duty), 64);
        enable = 1'b0;
        @(negedge clk);

        // capped initial duty, then voltage limit exit from P1
        pri_step = 10'd20; v_fb = 12'd4000; v_lim = 12'd4095;
        enable = 1'b1;
        @(negedge clk);
        check("R2 initial duty capped", int'(pri_duty), 200);
        v_lim = 12'd3000;
        @(negedge clk);
        check("R8 voltage exit", int'(handover), 1);
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule